// File: doc/BRIEF.md
# UART Receive Character Buffer with Error Status

This block is the receive-side store of a serial port. A receiver core delivers each completed character together with its framing and parity error indications. The block keeps a small FIFO of these characters and, for each one, records whether a line break was seen before it arrived. Software reaches the buffer through three accesses. A data read pops the oldest character. A status read is a plain view of the sticky error flags. An error clear write resets those flags.

Framing, parity and break in the status view describe the character most recently popped. Software must therefore read data first and status second. Overrun is the one flag that tracks the buffer itself. It rises as soon as a character arrives into a full buffer, and that character is thrown away. It falls once a read has freed a slot.

The break check is a duration counter on the raw receive line. A low level held for more than one frame time, given in clock cycles, marks the next character as a break character.

Top module: `rx_buffer_status`

## Requirements
- R1: After reset the status bits are all 0, the buffer is empty, and a data read returns 0.
- R2: Up to DEPTH (16) characters are held and are read back in arrival order. Bits 7:0 of the data word carry the character.
- R3: A character that completes while DEPTH characters are held, with no data read in the same cycle, is discarded. Status bit 3 (overrun) is 1 in the following cycle, with no read needed.
- R4: The overrun bit returns to 0 in the cycle after a data read frees a slot. A character that arrives in the same cycle as a read of a full buffer is stored and raises no overrun.
- R5: Status bits 2 (break), 1 (parity) and 0 (framing) change only when a data read pops a character. They are then loaded with that character's flags.
- R6: An error clear write sets all four status bits to 0 in the next cycle, and it wins over a load from a simultaneous pop. An overrun event in the same cycle leaves bit 3 at 1.
- R7: A data read of an empty buffer returns 0 and leaves every status bit unchanged.
- R8: If the line is sampled low on more than FRAME_CYCLES consecutive clock edges, the next completed character carries the break flag. A shorter low does not set it, and each marking is consumed by one character.
- R9: Bits 11:8 of the data word are, from high to low: the current overrun bit, and the break, parity and framing flags of the character being returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw receive line level, used for break timing |
| char_valid_i | input | 1 | One-cycle strobe: a character has completed |
| char_data_i | input | 8 | Completed character |
| char_frame_err_i | input | 1 | Framing error of the completed character |
| char_parity_err_i | input | 1 | Parity error of the completed character |
| data_rd_i | input | 1 | Data register read strobe; pops the oldest character |
| data_rdata_o | output | 12 | Data word: overrun, break, parity, framing, character |
| err_clr_i | input | 1 | Error clear write strobe; written value is irrelevant |
| status_o | output | 4 | Status: overrun, break, parity, framing (bit 3 to bit 0) |

## Verification
A wrong FIFO pointer or fill count shows up at the next data read. The data word then carries the wrong character or flags, or a full buffer accepts or drops a character one entry too early, which the following overrun bit exposes. A sticky flag updated on the wrong event appears on status_o one cycle after that event. Examples are a load on arrival instead of on pop, an overrun clear without a freed slot, or a clear losing to a load. An off-by-one in the break counter appears only in the break bit of the next character read.

// File: rtl/rx_buffer_pkg.sv
package rx_buffer_pkg;
  localparam int CHAR_W = 8;

  // one buffered character with its own error flags
  typedef struct packed {
    logic              brk;
    logic              par;
    logic              frm;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // sticky status, bit 3 down to bit 0
  typedef struct packed {
    logic ovr;
    logic brk;
    logic par;
    logic frm;
  } rx_status_t;

  localparam int STATUS_W = $bits(rx_status_t);
  localparam int RDATA_W  = ENTRY_W + 1;
endpackage

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rx_buffer_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  rx_entry_t wr_entry,
  input  logic      rd_en,
  output rx_entry_t rd_entry,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  rx_entry_t     slot_q [DEPTH];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (wr_en) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (rd_en) rd_ptr_d = ptr_inc(rd_ptr_q);
    if (wr_en && !rd_en) count_d = count_q + CW'(1);
    else if (rd_en && !wr_en) count_d = count_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage slots, each with its own write enable, no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_ptr_q == AW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= wr_entry;
    end
  end

  assign rd_entry = slot_q[rd_ptr_q];
  assign empty    = (count_q == '0);
  assign full     = (count_q == CW'(DEPTH));

  // R3: the parent never writes into a full buffer unless a pop frees a slot
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!full || rd_en));
  // R7: the parent never pops an empty buffer
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  // R2: a lone write to an empty buffer makes it non-empty
  assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en) |=> !empty);
endmodule

// File: rtl/rx_break_timer.sv
module rx_break_timer #(
  parameter int FRAME_CYCLES = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic char_done,
  output logic brk_tag
);
  localparam int CW = $clog2(FRAME_CYCLES + 1);

  logic [CW-1:0] low_cnt_q, low_cnt_d;
  logic          pend_q, pend_d;
  logic          at_limit;
  logic          set_now;

  assign at_limit = (low_cnt_q == CW'(FRAME_CYCLES));
  assign set_now  = !line_i && at_limit;

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (line_i)         low_cnt_d = '0;
    else if (!at_limit) low_cnt_d = low_cnt_q + CW'(1);

    pend_d = pend_q;
    if (char_done)    pend_d = 1'b0;
    else if (set_now) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_d;
      pend_q    <= pend_d;
    end
  end

  assign brk_tag = pend_q || set_now;

  // R8: a break marking only appears after the line was sampled low
  assert_brk_needs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(!line_i));
  // R8: a completed character consumes the marking
  assert_brk_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> !pend_q);
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import rx_buffer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pop,
  input  rx_entry_t  pop_entry,
  input  logic       ovf_evt,
  input  logic       clr,
  output rx_status_t status
);
  rx_status_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    // per-character flags: clear wins over a pop load
    if (clr) begin
      st_d.brk = 1'b0;
      st_d.par = 1'b0;
      st_d.frm = 1'b0;
    end else if (pop) begin
      st_d.brk = pop_entry.brk;
      st_d.par = pop_entry.par;
      st_d.frm = pop_entry.frm;
    end
    // overrun: a new overflow wins over every clearing cause
    if (ovf_evt)   st_d.ovr = 1'b1;
    else if (clr)  st_d.ovr = 1'b0;
    else if (pop)  st_d.ovr = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;

  // R3: overflow is visible the next cycle
  assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> status.ovr);
  // R6: a clear with no concurrent overflow empties the status
  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ovf_evt) |=> (status == '0));
  // R5 R7: with no pop, clear or overflow the status holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !clr && !ovf_evt) |=> $stable(status));
endmodule

// File: rtl/rx_buffer_status.sv
module rx_buffer_status
  import rx_buffer_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int FRAME_CYCLES = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              char_valid_i,
  input  logic [CHAR_W-1:0] char_data_i,
  input  logic              char_frame_err_i,
  input  logic              char_parity_err_i,
  input  logic              data_rd_i,
  output logic [RDATA_W-1:0] data_rdata_o,
  input  logic              err_clr_i,
  output logic [STATUS_W-1:0] status_o
);
  logic       rst_meta_q, rst_sync_q;
  logic       fifo_empty, fifo_full;
  logic       pop, ovf_evt, push;
  logic       brk_tag;
  rx_entry_t  in_entry, head;
  rx_status_t status;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign pop     = data_rd_i && !fifo_empty;
  assign ovf_evt = char_valid_i && fifo_full && !pop;
  assign push    = char_valid_i && !ovf_evt;

  assign in_entry.brk  = brk_tag;
  assign in_entry.par  = char_parity_err_i;
  assign in_entry.frm  = char_frame_err_i;
  assign in_entry.data = char_data_i;

  rx_break_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_brk (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .line_i    (line_i),
    .char_done (char_valid_i),
    .brk_tag   (brk_tag)
  );

  rx_char_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (push),
    .wr_entry (in_entry),
    .rd_en    (pop),
    .rd_entry (head),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  rx_status_regs u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .pop       (pop),
    .pop_entry (head),
    .ovf_evt   (ovf_evt),
    .clr       (err_clr_i),
    .status    (status)
  );

  assign data_rdata_o = fifo_empty ? '0 : {status.ovr, head};
  assign status_o     = status;

  // R7: reading an empty buffer yields zero
  assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (data_rd_i && fifo_empty) |-> (data_rdata_o == '0));
  // R9: the overrun bit of the data word matches the status view
  assert_word_ovr_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !fifo_empty |-> (data_rdata_o[RDATA_W-1] == status_o[STATUS_W-1]));
endmodule

// File: tb/rx_buffer_status_test.sv
`timescale 1ns/1ps
module rx_buffer_status_test;
  localparam int DEPTH = 16;
  localparam int FRAME = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_i, char_valid_i, char_frame_err_i, char_parity_err_i;
  logic [7:0]  char_data_i;
  logic        data_rd_i, err_clr_i;
  logic [11:0] data_rdata_o;
  logic [3:0]  status_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference model
  logic [10:0] q[$];
  logic [3:0]  st = 4'h0;
  int          low_run = 0;
  logic        bpend = 1'b0;

  always #2.5 clk = ~clk;

  rx_buffer_status #(.DEPTH(DEPTH), .FRAME_CYCLES(FRAME)) uut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .char_valid_i(char_valid_i),
    .char_data_i(char_data_i), .char_frame_err_i(char_frame_err_i),
    .char_parity_err_i(char_parity_err_i), .data_rd_i(data_rd_i),
    .data_rdata_o(data_rdata_o), .err_clr_i(err_clr_i), .status_o(status_o)
  );

  function automatic logic [11:0] exp_word(input logic [3:0] s, input logic [10:0] e);
    return {s[3], e};
  endfunction

  function automatic logic [3:0] next_status(input logic [3:0] s, input logic pop,
      input logic [10:0] e, input logic clr, input logic ovf);
    logic [3:0] n;
    n = s;
    if (clr) n[2:0] = 3'b000;
    else if (pop) n[2:0] = e[10:8];
    if (ovf) n[3] = 1'b1;
    else if (clr || pop) n[3] = 1'b0;
    return n;
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: entered right after a falling edge
  task automatic step(input logic push, input logic [7:0] d, input logic f,
      input logic p, input logic rd, input logic clr, input logic line, input string req);
    logic pop, ovf, tag;
    logic [10:0] head;
    char_valid_i = push; char_data_i = d; char_frame_err_i = f;
    char_parity_err_i = p; data_rd_i = rd; err_clr_i = clr; line_i = line;
    #1;
    pop  = rd && (q.size() > 0);
    head = (q.size() > 0) ? q[0] : 11'h0;
    if (rd) begin
      if (pop) check({req, " R2 R9 read"}, data_rdata_o, exp_word(st, head));
      else     check({req, " R7 empty read"}, data_rdata_o, 12'h000);
    end
    ovf = push && (q.size() == DEPTH) && !pop;
    if (!line) low_run++; else low_run = 0;
    if (low_run > FRAME) bpend = 1'b1;
    tag = bpend;
    if (push) bpend = 1'b0;
    st = next_status(st, pop, head, clr, ovf);
    if (pop) void'(q.pop_front());
    if (push && !ovf) q.push_back({tag, p, f, d});
    @(posedge clk);
    @(negedge clk);
    check({req, " R3 R4 R5 R6 status"}, {8'h0, status_o}, {8'h0, st});
  endtask

  task automatic idle(input logic line);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, line, "idle");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_i = 1'b1; char_valid_i = 1'b0; char_data_i = 8'h00;
    char_frame_err_i = 1'b0; char_parity_err_i = 1'b0; data_rd_i = 1'b0; err_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 status", {8'h0, status_o}, 12'h000);
    check("R1 data", data_rdata_o, 12'h000);

    // R2 R3: fill to capacity, then overflow with no read
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 8'(8'h30 + i), 1'(i % 3 == 0), 1'(i % 2), 1'b0, 1'b0, 1'b1, "R2 fill");
    step(1'b1, 8'hEE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3 overflow");
    check("R3 overrun bit", {11'h0, status_o[3]}, 12'h001);
    idle(1'b1);
    check("R3 overrun sticky", {11'h0, status_o[3]}, 12'h001);
    // R4 R9: first read shows overrun in bit 11, then overrun falls
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9 first read");
    check("R4 overrun cleared", {11'h0, status_o[3]}, 12'h000);
    for (int i = 1; i < DEPTH; i++)
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R2 drain");
    check("R3 dropped char absent", {11'h0, status_o[3]}, 12'h000);

    // R4: read of full buffer while a char arrives stores it, no overrun
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, 8'(8'hA0 + i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 fill");
    step(1'b1, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R4 swap");
    check("R4 no overrun", {11'h0, status_o[3]}, 12'h000);

    // R6: clear and overflow together keeps overrun
    step(1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 clr+ovf");
    check("R6 overrun kept", {11'h0, status_o[3]}, 12'h001);
    // R6: clear beats a pop load
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R6 clr+pop");
    check("R6 cleared", {8'h0, status_o}, 12'h000);
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5 drain");

    // R7: empty reads leave status unchanged
    step(1'b1, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R7 prep");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 pop");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 empty");
    check("R7 status kept", {8'h0, status_o}, 12'h003);

    // R8: low for exactly FRAME edges is no break, FRAME+1 is
    for (int i = 0; i < FRAME; i++) idle(1'b0);
    idle(1'b1);
    step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 short low");
    for (int i = 0; i < FRAME + 1; i++) idle(1'b0);
    idle(1'b1);
    step(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8 break char");
    step(1'b1, 8'h42, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 after break");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8 read short");
    check("R8 no break", {11'h0, status_o[2]}, 12'h000);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8 read break");
    check("R8 break set", {11'h0, status_o[2]}, 12'h001);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8 read consumed");
    check("R8 consumed", {11'h0, status_o[2]}, 12'h000);

    // random traffic with a fixed seed
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic lvl;
      r = $urandom_range(0, 99);
      lvl = (($urandom_range(0, 99)) < 93);
      step(1'(r < 55), 8'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 99) < 45),
           1'($urandom_range(0, 99) < 4), lvl, "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule